// File: doc/BRIEF.md
# GPIO Pin Input Level Resolver

This block works out the input data word of a general purpose I/O port from the port configuration and from the state of whatever drives the pins from outside. The register block supplies the following inputs:

- a two-bit mode code for each pin
- a one-bit output type for each pin, push-pull or open-drain
- a two-bit pull code for each pin
- the output data word

The external side makes drive requests for each pin, each with a level, and can release a pin at any time. The block stores which pins are connected and the level each connected source drives. A pin that nothing resolves, because it floats, keeps its last value.

The block protects against contention between an output driver and an external source. A drive request that would fight an active output is refused and raises a one-cycle conflict flag. When the configuration strobe marks a mode or output-type update, every connected source that would now fight an output driver is dropped. The block also gives a one-cycle rise pulse and a one-cycle fall pulse for each pin whenever the resolved input bit changes. Connected units use these pulses as level-change events.

Top module: `gpio_level_resolver`

## Requirements
- R1: A pin with mode code 01 (output) and output type 0 (push-pull) reads its output data bit.
- R2: A pin with mode code 01 and output type 1 (open-drain) whose output data bit is 0 reads 0.
- R3: An open-drain output pin whose output data bit is 1 reads 0 if it is connected to a low external level. If it is not connected, or its connected level is high, it reads 1 under pull-up and 0 under pull-down, and with no pull it keeps its previous value.
- R4: A pin with mode code 00, 10 or 11 (not output) reads its connected external level. When disconnected, it reads 1 under pull-up and 0 under pull-down, and with no pull it keeps its previous value.
- R5: Pull code 01 selects pull-up and pull code 10 selects pull-down. Codes 00 and 11 select no pull.
- R6: A drive request on an output pin is refused unless that pin is open-drain and the requested level is 0. A refused request leaves the connection unchanged and sets that pin's conflict_o bit for exactly the following cycle. An accepted request connects the pin at the requested level.
- R7: In a cycle with cfg_wr_i high, a pin is disconnected if it is connected and in output mode and is either push-pull or connected high. If a request and a release both arrive in that cycle, they are applied first.
- R8: A release strobe disconnects its pin and takes priority over a drive request in the same cycle.
- R9: While reset is asserted, every pin is disconnected, every external level is low, and idr_o, pin_rise_o, pin_fall_o and conflict_o are all zero.
- R10: A pin's pin_rise_o bit pulses for one cycle when its idr_o bit changes from 0 to 1, and its pin_fall_o bit pulses for one cycle when the bit changes from 1 to 0. Neither pulses while the bit stays unchanged.
- R11: Every output reflects the inputs sampled at the preceding rising clock edge, so an effect appears exactly one cycle after its stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2*NUM_PINS | Mode code for each pin; 01 means output |
| otype_i | input | NUM_PINS | Output type for each pin; 1 means open-drain |
| pull_i | input | 2*NUM_PINS | Pull code for each pin |
| odr_i | input | NUM_PINS | Output data word |
| cfg_wr_i | input | 1 | Strobe marking a mode or output-type update |
| drive_req_i | input | NUM_PINS | External drive request for each pin |
| drive_lvl_i | input | NUM_PINS | Requested external level for each pin |
| release_i | input | NUM_PINS | External disconnect strobe for each pin |
| idr_o | output | NUM_PINS | Resolved input data word |
| pin_rise_o | output | NUM_PINS | One-cycle pulse on a 0-to-1 change of the bit |
| pin_fall_o | output | NUM_PINS | One-cycle pulse on a 1-to-0 change of the bit |
| conflict_o | output | NUM_PINS | One-cycle flag for a refused drive request |

## Verification
Every result is due exactly one rising edge after its stimulus. This holds for idr_o, the rise and fall pulses, and the conflict flags, because the resolver acts on the connection state that the same edge will store. The bench changes inputs on the falling edge and waits for the next rising edge. It then compares all four outputs at the following falling edge with a reference model, which advances one step at each edge. The directed cases check the floating-hold behaviour, drops caused by the configuration strobe, releases and refused requests. Each of these is followed by further steps, so the stored connection state shows up on idr_o.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam logic [1:0] MODE_OUT  = 2'b01;
  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DOWN = 2'b10;
endpackage

// File: rtl/gpio_conn_tracker.sv
module gpio_conn_tracker #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] is_out_i,
  input  logic [NUM_PINS-1:0] is_od_i,
  input  logic                cfg_wr_i,
  input  logic [NUM_PINS-1:0] req_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rel_i,
  output logic [NUM_PINS-1:0] conn_nxt_o,
  output logic [NUM_PINS-1:0] ext_nxt_o,
  output logic [NUM_PINS-1:0] conflict_o
);
  logic [NUM_PINS-1:0] conn_q, ext_q, accept, conflict_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic c_a, c_r;
    assign accept[i] = ~is_out_i[i] | (is_od_i[i] & ~lvl_i[i]);
    assign ext_nxt_o[i] = (req_i[i] & accept[i]) ? lvl_i[i] : ext_q[i];
    assign c_a = (req_i[i] & accept[i]) | conn_q[i];
    assign c_r = c_a & ~rel_i[i];
    // config strobe drops sources that would fight an output driver
    assign conn_nxt_o[i] = c_r & ~(cfg_wr_i & is_out_i[i] & (~is_od_i[i] | ext_nxt_o[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q     <= '0;
      ext_q      <= '0;
      conflict_q <= '0;
    end else begin
      conn_q     <= conn_nxt_o;
      ext_q      <= ext_nxt_o;
      conflict_q <= req_i & ~accept;
    end
  end

  assign conflict_o = conflict_q;
endmodule

// File: rtl/gpio_bit_resolver.sv
module gpio_bit_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0]   is_out_i,
  input  logic [NUM_PINS-1:0]   is_od_i,
  input  logic [2*NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0]   odr_i,
  input  logic [NUM_PINS-1:0]   conn_i,
  input  logic [NUM_PINS-1:0]   ext_i,
  input  logic [NUM_PINS-1:0]   prev_i,
  output logic [NUM_PINS-1:0]   idr_d_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    logic pu, pd, pulled;
    assign pu = (pull_i[2*i +: 2] == PULL_UP);
    assign pd = (pull_i[2*i +: 2] == PULL_DOWN);
    assign pulled = pu ? 1'b1 : (pd ? 1'b0 : prev_i[i]);

    always_comb begin
      if (is_out_i[i]) begin
        if (!is_od_i[i])                 idr_d_o[i] = odr_i[i];
        else if (!odr_i[i])              idr_d_o[i] = 1'b0;
        else if (conn_i[i] && !ext_i[i]) idr_d_o[i] = 1'b0;
        else                             idr_d_o[i] = pulled;
      end else if (conn_i[i]) begin
        idr_d_o[i] = ext_i[i];
      end else begin
        idr_d_o[i] = pulled;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_reg.sv
module gpio_edge_reg #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] idr_d_i,
  output logic [NUM_PINS-1:0] idr_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idr_o  <= '0;
      rise_o <= '0;
      fall_o <= '0;
    end else begin
      idr_o  <= idr_d_i;
      rise_o <= idr_d_i & ~idr_o;
      fall_o <= ~idr_d_i & idr_o;
    end
  end
endmodule

// File: rtl/gpio_level_resolver.sv
module gpio_level_resolver
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0]   otype_i,
  input  logic [2*NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0]   odr_i,
  input  logic                  cfg_wr_i,
  input  logic [NUM_PINS-1:0]   drive_req_i,
  input  logic [NUM_PINS-1:0]   drive_lvl_i,
  input  logic [NUM_PINS-1:0]   release_i,
  output logic [NUM_PINS-1:0]   idr_o,
  output logic [NUM_PINS-1:0]   pin_rise_o,
  output logic [NUM_PINS-1:0]   pin_fall_o,
  output logic [NUM_PINS-1:0]   conflict_o
);
  logic [NUM_PINS-1:0] is_out, conn_nxt, ext_nxt, idr_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mode
    assign is_out[i] = (mode_i[2*i +: 2] == MODE_OUT);
  end

  gpio_conn_tracker #(.NUM_PINS(NUM_PINS)) u_conn (
    .clk_i, .rst_ni,
    .is_out_i   (is_out),
    .is_od_i    (otype_i),
    .cfg_wr_i,
    .req_i      (drive_req_i),
    .lvl_i      (drive_lvl_i),
    .rel_i      (release_i),
    .conn_nxt_o (conn_nxt),
    .ext_nxt_o  (ext_nxt),
    .conflict_o
  );

  gpio_bit_resolver #(.NUM_PINS(NUM_PINS)) u_res (
    .is_out_i (is_out),
    .is_od_i  (otype_i),
    .pull_i,
    .odr_i,
    .conn_i   (conn_nxt),
    .ext_i    (ext_nxt),
    .prev_i   (idr_o),
    .idr_d_o  (idr_d)
  );

  gpio_edge_reg #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i, .rst_ni,
    .idr_d_i (idr_d),
    .idr_o,
    .rise_o  (pin_rise_o),
    .fall_o  (pin_fall_o)
  );
endmodule

// File: rtl/gpio_level_resolver_chk.sv
module gpio_level_resolver_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [2*NUM_PINS-1:0] mode_i,
  input logic [NUM_PINS-1:0]   otype_i,
  input logic [NUM_PINS-1:0]   odr_i,
  input logic [NUM_PINS-1:0]   drive_req_i,
  input logic [NUM_PINS-1:0]   drive_lvl_i,
  input logic [NUM_PINS-1:0]   idr_o,
  input logic [NUM_PINS-1:0]   pin_rise_o,
  input logic [NUM_PINS-1:0]   pin_fall_o,
  input logic [NUM_PINS-1:0]   conflict_o
);
  logic past_ok;
  logic [NUM_PINS-1:0] pp_m, od0_m, legal_m;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_m
    assign pp_m[i]    = (mode_i[2*i +: 2] == 2'b01) & ~otype_i[i];
    assign od0_m[i]   = (mode_i[2*i +: 2] == 2'b01) & otype_i[i] & ~odr_i[i];
    assign legal_m[i] = (mode_i[2*i +: 2] != 2'b01) | (otype_i[i] & ~drive_lvl_i[i]);
  end

  a_r1_pushpull_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (((idr_o ^ $past(odr_i)) & $past(pp_m)) == '0));

  a_r2_od_low_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((idr_o & $past(od0_m)) == '0));

  a_r6_conflict_only_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((conflict_o & ~($past(drive_req_i) & ~$past(legal_m))) == '0));

  a_r10_rise_tracks_idr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (pin_rise_o == (idr_o & ~$past(idr_o))));

  a_r10_fall_tracks_idr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (pin_fall_o == (~idr_o & $past(idr_o))));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_quiet: assert ((idr_o | pin_rise_o | pin_fall_o | conflict_o) == '0);
    end
  end
endmodule

bind gpio_level_resolver gpio_level_resolver_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .otype_i     (otype_i),
  .odr_i       (odr_i),
  .drive_req_i (drive_req_i),
  .drive_lvl_i (drive_lvl_i),
  .idr_o       (idr_o),
  .pin_rise_o  (pin_rise_o),
  .pin_fall_o  (pin_fall_o),
  .conflict_o  (conflict_o)
);

// File: tb/gpio_level_resolver_tb.sv
module gpio_level_resolver_tb;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2*N-1:0] mode = '0, pull = '0;
  logic [N-1:0] otype = '0, odr = '0, req = '0, lvl = '0, rel = '0;
  logic cfg_wr = 1'b0;
  logic [N-1:0] idr, rise, fall, confl;

  logic [N-1:0] m_conn = '0, m_ext = '0, m_idr = '0;
  logic [N-1:0] e_idr, e_rise, e_fall, e_conf, e_conn, e_ext;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_level_resolver #(.NUM_PINS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
    .odr_i(odr), .cfg_wr_i(cfg_wr), .drive_req_i(req), .drive_lvl_i(lvl),
    .release_i(rel), .idr_o(idr), .pin_rise_o(rise), .pin_fall_o(fall),
    .conflict_o(confl)
  );

  function automatic logic resolve(logic out, logic od, logic [1:0] pl, logic d,
                                   logic c, logic e, logic prev);
    logic fl;
    fl = (pl == 2'b01) ? 1'b1 : ((pl == 2'b10) ? 1'b0 : prev);
    if (out) begin
      if (!od) return d;
      if (!d) return 1'b0;
      if (c && !e) return 1'b0;
      return fl;
    end
    return c ? e : fl;
  endfunction

  function automatic string req_of(int i);
    if (mode[2*i +: 2] != 2'b01) return "R4";
    if (!otype[i]) return "R1";
    if (!odr[i]) return "R2";
    return "R3";
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic predict();
    for (int i = 0; i < N; i++) begin
      logic out, acc, c, e;
      out = (mode[2*i +: 2] == 2'b01);
      acc = !out || (otype[i] && !lvl[i]);
      e_conf[i] = req[i] && !acc;
      c = m_conn[i]; e = m_ext[i];
      if (req[i] && acc) begin c = 1'b1; e = lvl[i]; end
      if (rel[i]) c = 1'b0;
      if (cfg_wr && c && out && (!otype[i] || e)) c = 1'b0;
      e_conn[i] = c; e_ext[i] = e;
      e_idr[i] = resolve(out, otype[i], pull[2*i +: 2], odr[i], c, e, m_idr[i]);
    end
    e_rise = e_idr & ~m_idr;
    e_fall = ~e_idr & m_idr;
  endtask

  // R11: one edge from stimulus to every output
  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    if (idr !== e_idr) begin
      int k = 0;
      for (int i = 0; i < N; i++) if (idr[i] !== e_idr[i]) begin k = i; break; end
      chk(1'b0, {req_of(k), "/R11 idr"}, 32'(idr), 32'(e_idr));
    end else chk(1'b1, "R11", 0, 0);
    chk(rise === e_rise && fall === e_fall, "R10/R11 edges",
        {rise, fall}, {e_rise, e_fall});
    chk(confl === e_conf, "R6 conflict", 32'(confl), 32'(e_conf));
    m_conn = e_conn; m_ext = e_ext; m_idr = e_idr;
    cfg_wr = 1'b0; req = '0; rel = '0;
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk((idr | rise | fall | confl) === '0, "R9 reset outputs", 32'(idr), 0);
    rst_n = 1'b1;

    // R4/R8: connect pin0 high under pull-down, then release
    pull[1:0] = 2'b10; req[0] = 1'b1; lvl[0] = 1'b1; step();
    chk(idr[0] === 1'b1, "R4 connected high", 32'(idr[0]), 1);
    rel[0] = 1'b1; step();
    chk(idr[0] === 1'b0, "R8 release to pull-down", 32'(idr[0]), 0);
    req[0] = 1'b1; lvl[0] = 1'b1; rel[0] = 1'b1; step();
    chk(idr[0] === 1'b0, "R8 release beats request", 32'(idr[0]), 0);

    // R5: pull-up then codes 11 and 00 hold the value
    pull[3:2] = 2'b01; step();
    chk(idr[1] === 1'b1, "R5 pull-up", 32'(idr[1]), 1);
    pull[3:2] = 2'b11; step();
    chk(idr[1] === 1'b1, "R5 code 11 holds", 32'(idr[1]), 1);
    pull[3:2] = 2'b00; step();
    chk(idr[1] === 1'b1, "R5 code 00 holds", 32'(idr[1]), 1);

    // R7: connected-high pin made push-pull output with strobe is dropped
    pull[5:4] = 2'b10; req[2] = 1'b1; lvl[2] = 1'b1; step();
    mode[5:4] = 2'b01; odr[2] = 1'b0; cfg_wr = 1'b1; step();
    chk(idr[2] === 1'b0, "R1 push-pull reads odr", 32'(idr[2]), 0);
    mode[5:4] = 2'b00; step();
    chk(idr[2] === 1'b0, "R7 source dropped", 32'(idr[2]), 0);

    // R6: request on push-pull output refused; R3 open-drain low accepted
    mode[7:6] = 2'b01; req[3] = 1'b1; lvl[3] = 1'b1; step();
    chk(confl[3] === 1'b1, "R6 refused flag", 32'(confl), 32'h8);
    step();
    chk(confl[3] === 1'b0, "R6 flag one cycle", 32'(confl), 0);
    mode[9:8] = 2'b01; otype[4] = 1'b1; odr[4] = 1'b1; pull[9:8] = 2'b01; step();
    chk(idr[4] === 1'b1, "R3 open-drain pulled up", 32'(idr[4]), 1);
    req[4] = 1'b1; lvl[4] = 1'b0; step();
    chk(idr[4] === 1'b0 && confl[4] === 1'b0, "R3 open-drain held low", 32'(idr[4]), 0);
    odr[4] = 1'b0; step();
    chk(idr[4] === 1'b0, "R2 open-drain zero", 32'(idr[4]), 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) begin
        mode = {$urandom(), $urandom()}; cfg_wr = ($urandom_range(0, 1) == 1);
      end
      if ($urandom_range(0, 7) == 0) otype = N'($urandom());
      if ($urandom_range(0, 5) == 0) pull = $urandom();
      if ($urandom_range(0, 3) == 0) odr = N'($urandom());
      if ($urandom_range(0, 5) == 0) cfg_wr = 1'b1;
      req = N'($urandom() & $urandom());
      lvl = N'($urandom());
      rel = N'($urandom() & $urandom() & $urandom());
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule